// File: doc/BRIEF.md
# Round-Robin Thread Block Dispatcher

This block distributes the independent thread blocks of one kernel over a set of compute cores. A kernel is launched with its total block count and a per-core ceiling on resident blocks. The dispatcher then offers blocks one at a time, moving breadth-first across the cores. A core gets a second block only after every core with room has had one, and a core that holds its ceiling is passed over. Cores raise a one-cycle completion pulse when a block retires, which frees a slot for reuse.

Block indices are handed out in increasing order from zero. Any core may run any block. Only one kernel is in flight at a time. The launch channel accepts a new kernel only once every block of the current one has been issued and has retired. At that point a done flag rises and stays high until the next launch is accepted.

Both the launch channel and the assignment channel use valid/ready handshakes:

- **Launch channel.** A launch transfers on a clock edge where `launch_valid` and `launch_ready` are both high. `launch_ready` depends only on whether a kernel is active.
- **Assignment channel.** An assignment transfers on an edge where one bit of `assign_valid` and `assign_ready` are both high. While `assign_ready` is low, the offer does not change: it keeps the same core bit and the same index until it is taken. This holds even if a completion frees a core that would otherwise have priority.

Top module: `rr_block_dispatch`

## Requirements
- R1: `launch_ready` is high exactly when no kernel is active. A launch presented while a kernel is active is ignored. `kernel_done` is low after the edge that accepts a launch. No assignment is offered while no kernel is active.
- R2: At most one bit of `assign_valid` is high in any cycle, so at most one block is assigned per clock.
- R3: Within a kernel, the first offered `assign_index` is 0, and each accepted assignment increases it by exactly 1.
- R4: With ample blocks, after launch the first N assignments go to cores 0, 1, …, N-1 in that order (bit i of `assign_valid` selects core i). The next N assignments follow the same order again if every core still has room.
- R5: A core that holds as many blocks as the kernel's resident limit is never offered a block. No more blocks than the launched count are ever offered.
- R6: A pulse on `retire[i]` lowers core i's resident count by one, so the core can be offered a block again. A pulse on a core that holds no block is ignored.
- R7: The search for the next core starts at the core after the one most recently assigned, wrapping from N-1 to 0.
- R8: While `assign_valid` is non-zero and `assign_ready` is low, both `assign_valid` and `assign_index` keep their values on the next cycle.
- R9: `kernel_done` rises once all blocks are issued and every core is empty, and stays high until the next launch is accepted. For a zero block count, it is high after the second rising edge counting the accepting edge, and no block is offered.
- R10: A resident limit of 0 given at launch is treated as a limit of 1.
- R11: After reset, `launch_ready` is 1, `assign_valid` is 0 and `kernel_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | A kernel launch is presented |
| launch_ready | output | 1 | Dispatcher idle, launch can be taken |
| launch_count | input | CNT_W | Number of blocks in the kernel |
| launch_limit | input | OCC_W | Resident block ceiling per core for this kernel |
| assign_valid | output | NUM_CORES | One-hot offer: bit i targets core i |
| assign_ready | input | 1 | The offered block is taken this cycle |
| assign_index | output | CNT_W | Index of the offered block |
| retire | input | NUM_CORES | One-cycle completion pulse per core |
| kernel_done | output | 1 | All blocks of the last kernel issued and retired |

## Verification
The hardest state to reach is a stalled offer during which a completion frees a core that the rotating search would now prefer. The bench gets there in three steps. First it fills every core to a ceiling of one. Then it retires one core so that an offer appears, and holds back-pressure on that offer. Finally it retires a core earlier in the search order while the stall lasts. A second hard case is a completion pulse on an empty core, since an underflow there is invisible until a later kernel. The bench pulses core 0 while idle and then checks that the next kernel's first block still goes to core 0.

// File: rtl/rr_disp_pkg.sv
package rr_disp_pkg;

  typedef enum logic {
    K_IDLE = 1'b0,
    K_RUN  = 1'b1
  } kstate_e;

  // Modular step around a ring of n positions.
  function automatic int wrap_add(input int base, input int off, input int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
  import rr_disp_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);

  // Search starts one past the most recent winner and wraps.
  always_comb begin
    int c;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int off = 1; off <= N; off++) begin
      c = wrap_add(int'(last), off, N);
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

endmodule

// File: rtl/occ_slot.sv
module occ_slot #(
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             free,
  input  logic [OCC_W-1:0] lim,
  output logic [OCC_W-1:0] occ,
  output logic             room
);

  logic dec_ok;

  // A completion on an empty core has nothing to retire.
  assign dec_ok = free && (occ != '0);
  assign room   = (occ < lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (take && !dec_ok) begin
      occ <= occ + 1'b1;
    end else if (!take && dec_ok) begin
      occ <= occ - 1'b1;
    end
  end

endmodule

// File: rtl/rr_block_dispatch.sv
module rr_block_dispatch
  import rr_disp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int OCC_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  output logic                 launch_ready,
  input  logic [CNT_W-1:0]     launch_count,
  input  logic [OCC_W-1:0]     launch_limit,
  output logic [NUM_CORES-1:0] assign_valid,
  input  logic                 assign_ready,
  output logic [CNT_W-1:0]     assign_index,
  input  logic [NUM_CORES-1:0] retire,
  output logic                 kernel_done
);

  localparam int IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [IW-1:0] LAST_CORE = IW'(NUM_CORES - 1);

  kstate_e                          st;
  logic [CNT_W-1:0]                 total_q;
  logic [CNT_W-1:0]                 issued_q;
  logic [OCC_W-1:0]                 lim_q;
  logic [IW-1:0]                    last_q;
  logic                             hold_v;
  logic [IW-1:0]                    hold_idx;
  logic [NUM_CORES-1:0][OCC_W-1:0]  occ;
  logic [NUM_CORES-1:0]             room;
  logic [NUM_CORES-1:0]             req;
  logic [NUM_CORES-1:0]             arb_gnt;
  logic [IW-1:0]                    arb_idx;
  logic                             arb_any;
  logic [IW-1:0]                    sel_idx;
  logic                             more;
  logic                             offer;
  logic                             fire;
  logic                             launch_fire;
  logic                             fin;
  logic [NUM_CORES-1:0]             take;

  assign launch_ready = (st == K_IDLE);
  assign launch_fire  = launch_valid && launch_ready;
  assign more         = (st == K_RUN) && (issued_q != total_q);
  assign req          = room & {NUM_CORES{more}};

  rr_pick #(.N(NUM_CORES), .IW(IW)) u_pick (
    .req     (req),
    .last    (last_q),
    .gnt     (arb_gnt),
    .gnt_idx (arb_idx),
    .any     (arb_any)
  );

  // A stalled offer is locked so the target core cannot change under it.
  assign sel_idx = hold_v ? hold_idx : arb_idx;
  assign offer   = hold_v || (more && arb_any);
  assign fire    = offer && assign_ready;
  assign fin     = (st == K_RUN) && !more && (occ == '0);

  assign assign_index = issued_q;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign assign_valid[g] = offer && (sel_idx == IW'(g));
    assign take[g]         = fire && (sel_idx == IW'(g));

    occ_slot #(.OCC_W(OCC_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take[g]),
      .free  (retire[g]),
      .lim   (lim_q),
      .occ   (occ[g]),
      .room  (room[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= K_IDLE;
      total_q     <= '0;
      issued_q    <= '0;
      lim_q       <= OCC_W'(1);
      last_q      <= LAST_CORE;
      hold_v      <= 1'b0;
      hold_idx    <= '0;
      kernel_done <= 1'b0;
    end else if (launch_fire) begin
      st          <= K_RUN;
      total_q     <= launch_count;
      issued_q    <= '0;
      lim_q       <= (launch_limit == '0) ? OCC_W'(1) : launch_limit;
      last_q      <= LAST_CORE;
      hold_v      <= 1'b0;
      kernel_done <= 1'b0;
    end else if (st == K_RUN) begin
      if (fire) begin
        issued_q <= issued_q + 1'b1;
        last_q   <= sel_idx;
        hold_v   <= 1'b0;
      end else if (offer) begin
        hold_v   <= 1'b1;
        hold_idx <= sel_idx;
      end
      if (fin) begin
        st          <= K_IDLE;
        kernel_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rr_dispatch_chk.sv
module rr_dispatch_chk #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int OCC_W     = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                launch_ready,
  input logic [NUM_CORES-1:0]                assign_valid,
  input logic                                assign_ready,
  input logic [CNT_W-1:0]                    assign_index,
  input logic                                kernel_done,
  input logic [NUM_CORES-1:0][OCC_W-1:0]     occ,
  input logic [OCC_W-1:0]                    lim_q
);

  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(assign_valid)); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|assign_valid) && assign_ready) |=>
      (!(|assign_valid) || (assign_index == $past(assign_index) + 1'b1))); // R3

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|assign_valid) && !assign_ready) |=>
      ((assign_valid == $past(assign_valid)) && (assign_index == $past(assign_index)))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> (assign_valid == '0)); // R1

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_done |-> launch_ready); // R9

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_full
    AST_FULL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      assign_valid[g] |-> (occ[g] < lim_q)); // R5
  end

endmodule

bind rr_block_dispatch rr_dispatch_chk #(
  .NUM_CORES (NUM_CORES),
  .CNT_W     (CNT_W),
  .OCC_W     (OCC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_ready (launch_ready),
  .assign_valid (assign_valid),
  .assign_ready (assign_ready),
  .assign_index (assign_index),
  .kernel_done  (kernel_done),
  .occ          (occ),
  .lim_q        (lim_q)
);

// File: tb/sim_rr_block_dispatch.sv
module sim_rr_block_dispatch;

  localparam int NC  = 4;
  localparam int CW  = 16;
  localparam int OW  = 4;

  logic          clk;
  logic          rst_n;
  logic          launch_valid;
  logic          launch_ready;
  logic [CW-1:0] launch_count;
  logic [OW-1:0] launch_limit;
  logic [NC-1:0] assign_valid;
  logic          assign_ready;
  logic [CW-1:0] assign_index;
  logic [NC-1:0] retire;
  logic          kernel_done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  rr_block_dispatch #(.NUM_CORES(NC), .CNT_W(CW), .OCC_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_count(launch_count), .launch_limit(launch_limit),
    .assign_valid(assign_valid), .assign_ready(assign_ready),
    .assign_index(assign_index), .retire(retire),
    .kernel_done(kernel_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_offer(input int core, input int idx, input string tag);
    chk("R2", "offer bit count", $countones(assign_valid), 1);
    chk(tag, "offer core vector", assign_valid, longint'(1) << core);
    chk("R3", "offer index", assign_index, idx);
  endtask

  task automatic expect_none(input string tag);
    chk(tag, "no offer", assign_valid, 0);
  endtask

  task automatic do_launch(input int cnt, input int lim);
    launch_valid = 1'b1;
    launch_count = CW'(cnt);
    launch_limit = OW'(lim);
    chk("R1", "launch_ready before launch", launch_ready, 1);
    step();
    launch_valid = 1'b0;
    chk("R1", "done cleared on launch", kernel_done, 0);
    chk("R1", "busy after launch", launch_ready, 0);
  endtask

  task automatic pulse(input logic [NC-1:0] v);
    retire = v;
    step();
    retire = '0;
  endtask

  task automatic drain_and_finish();
    for (int k = 0; k < 3; k++) pulse('1);
    step();
    chk("R9", "kernel_done after drain", kernel_done, 1);
    chk("R9", "launch_ready after drain", launch_ready, 1);
  endtask

  task automatic t_reset();
    chk("R11", "launch_ready at reset", launch_ready, 1);
    chk("R11", "assign_valid at reset", assign_valid, 0);
    chk("R11", "kernel_done at reset", kernel_done, 0);
  endtask

  // Limit 1, count 6: fill, busy launch ignored, refill and rotation.
  task automatic t_fill_one();
    pulse(4'b0001);  // stray completion on empty core 0 (R6)
    do_launch(6, 1);
    chk("R6", "stray pulse ignored, core 0 first", assign_valid, 1);
    for (int k = 0; k < NC; k++) begin
      expect_offer(k, k, "R4");
      step();
    end
    expect_none("R5");
    launch_valid = 1'b1;
    launch_count = CW'(9);
    launch_limit = OW'(3);
    chk("R1", "launch_ready while busy", launch_ready, 0);
    step();
    launch_valid = 1'b0;
    chk("R1", "busy launch ignored index", assign_index, 4);
    expect_none("R1");
    pulse(4'b0100);
    expect_offer(2, 4, "R6");
    step();
    pulse(4'b1010);
    expect_offer(3, 5, "R7");
    step();
    expect_none("R5");
    drain_and_finish();
  endtask

  // Limit 2, count 10: two breadth-first rounds then rotation.
  task automatic t_two_rounds();
    do_launch(10, 2);
    for (int k = 0; k < 2 * NC; k++) begin
      expect_offer(k % NC, k, "R4");
      step();
    end
    expect_none("R5");
    pulse(4'b0001);
    expect_offer(0, 8, "R6");
    step();
    pulse(4'b0011);
    expect_offer(1, 9, "R7");
    step();
    expect_none("R5");
    drain_and_finish();
  endtask

  // Back-pressure while a preferred core becomes free.
  task automatic t_stall();
    do_launch(5, 1);
    for (int k = 0; k < NC; k++) step();
    expect_none("R5");
    assign_ready = 1'b0;
    pulse(4'b0100);
    expect_offer(2, 4, "R8");
    pulse(4'b0001);
    expect_offer(2, 4, "R8");
    assign_ready = 1'b1;
    step();
    expect_none("R5");
    drain_and_finish();
  endtask

  task automatic t_zero();
    do_launch(0, 3);
    expect_none("R9");
    step();
    chk("R9", "done for zero count", kernel_done, 1);
    chk("R9", "ready for zero count", launch_ready, 1);
    expect_none("R9");
  endtask

  task automatic t_limit_zero();
    do_launch(5, 0);
    for (int k = 0; k < NC; k++) begin
      expect_offer(k, k, "R10");
      step();
    end
    expect_none("R10");
    pulse('1);
    expect_offer(0, 4, "R10");
    step();
    drain_and_finish();
  endtask

  initial begin
    rst_n        = 1'b0;
    launch_valid = 1'b0;
    launch_count = '0;
    launch_limit = '0;
    assign_ready = 1'b1;
    retire       = '0;
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill_one();
    t_two_rounds();
    t_stall();
    t_zero();
    t_limit_zero();
    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule